// File: doc/BRIEF.md
# 65xx Bus Address and Strobe Decoder

This block sits between a 6502-class processor bus and the memories and peripherals on it. It looks at address bits A15..A4 together with the read/write line and the second clock phase. From these it produces RAM and ROM chip selects, one select shared by up to four 65xx-family peripherals, a select for an expansion I/O window, two enables for addressable output latches, and a read strobe and a write strobe for memories and for peripherals that use separate read and write pins.

Chip selects come from the address alone, so they are already settled when the clock phase rises. That is the timing 65xx peripherals expect. The read and write strobes and the latch enables are gated by the high clock phase, so they pace the transfer itself. The 65xx peripherals share one select. Each of them also takes one of A7..A4 as its positive chip select, which tells them apart. The sixteen bytes directly above RAM decode to nothing, so a routine that probes for the top of RAM never reaches a peripheral.

Top module: `bus_decoder_65`

## Requirements
- R1: `rd_n` is low exactly when `rw` is 1 and `phi2` is 1.
- R2: `wr_n` is low exactly when `rw` is 0 and `phi2` is 1.
- R3: `per65_cs_n` is low exactly when A15..A8 equals 0x80 and the nibble A7..A4 is 0x1, 0x2, 0x4 or 0x8. It does not depend on `phi2` or `rw`.
- R4: `latch0_en_n` is low exactly when A15..A4 equals 0x805 and `phi2` is 1. `latch1_en_n` is low exactly when A15..A4 equals 0x806 and `phi2` is 1.
- R5: `xio_cs_n` is low exactly for byte addresses 0x80C0 through 0x80FF. It does not depend on `phi2` or `rw`.
- R6: `ram_cs_n` is low exactly when A15 is 0. `rom_cs_n` is low exactly when A15 and A14 are both 1. Neither depends on `phi2` or `rw`.
- R7: For A15..A4 equal to 0x800, every select and every latch enable is high.
- R8: For any input, at most one of `ram_cs_n`, `rom_cs_n`, `per65_cs_n`, `xio_cs_n`, `latch0_en_n` and `latch1_en_n` is low.
- R9: `rd_n` and `wr_n` are never low together. While `phi2` is 0, both strobes and both latch enables are high, whatever the address and `rw`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_hi | input | 12 | Bus address bits A15..A4 (bit 11 = A15) |
| rw | input | 1 | Bus direction: 1 = read, 0 = write |
| phi2 | input | 1 | Second clock phase of the bus |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| per65_cs_n | output | 1 | Shared 65xx peripheral select, active low |
| latch0_en_n | output | 1 | First latch enable, active low |
| latch1_en_n | output | 1 | Second latch enable, active low |
| xio_cs_n | output | 1 | Expansion I/O select, active low |
| ram_cs_n | output | 1 | RAM select, active low |
| rom_cs_n | output | 1 | ROM select, active low |

## Verification
During the high clock phase, a strobe and a latch enable assert in the same cycle. For example, a write to 0x8050 drives `wr_n` and `latch0_en_n` low together, and a read of 0x8060 drives `rd_n` and `latch1_en_n` low together. Each address is therefore applied under all four combinations of `rw` and `phi2`, with a seeded random mix added on top. Every output is compared with a reference computed from byte-address ranges. For each vector the bench also judges that no two strobes are low together and that no two selects are low together.

// File: rtl/bus_dec_pkg.sv
// Package: shared widths and constants for the 65xx bus decoder.
// Assumes the decoder sees A15..A4, so the lowest address nibble is never decoded.
package bus_dec_pkg;
    localparam int ADDR_W    = 12;       // A15..A4
    localparam int NIB_W     = 4;        // A7..A4
    localparam int PAGE_W    = 8;        // A15..A8
    localparam logic [PAGE_W-1:0] IO_PAGE  = 8'h80;
    localparam logic [NIB_W-1:0]  LAT0_NIB = 4'h5;
    localparam logic [NIB_W-1:0]  LAT1_NIB = 4'h6;
    localparam int PER_COUNT = 4;        // one window per bit of A7..A4
endpackage

// File: rtl/strobe_gen.sv
// Module: strobe_gen
// Builds active-high read and write enables from bus direction and clock phase.
// Assumes rw is stable while phi2 is high.
module strobe_gen (
    input  logic rw,
    input  logic phi2,
    output logic rd_en,
    output logic wr_en
);
    // Gate the direction with the high clock phase.
    always_comb begin
        rd_en = rw & phi2;
        wr_en = ~rw & phi2;
    end
endmodule

// File: rtl/region_dec.sv
// Module: region_dec
// Decodes the coarse memory map: RAM (lower half), ROM (top quarter) and
// the single I/O page. All outputs are address-only, never clock gated.
// Assumes ADDR_W >= PAGE_W.
module region_dec #(
    parameter int ADDR_W = bus_dec_pkg::ADDR_W,
    parameter int PAGE_W = bus_dec_pkg::PAGE_W,
    parameter logic [PAGE_W-1:0] IO_PAGE = bus_dec_pkg::IO_PAGE
) (
    input  logic [ADDR_W-1:0] addr_hi,
    output logic              ram_hit,
    output logic              rom_hit,
    output logic              page_hit
);
    localparam int TOP = ADDR_W - 1;

    // Compare the upper address bits against each region.
    always_comb begin
        ram_hit  = ~addr_hi[TOP];
        rom_hit  = addr_hi[TOP] & addr_hi[TOP-1];
        page_hit = (addr_hi[TOP -: PAGE_W] == IO_PAGE);
    end
endmodule

// File: rtl/io_dec.sv
// Module: io_dec
// Splits the I/O page by nibble A7..A4 into the shared 65xx select (one-hot
// nibble windows), two clock-qualified latch enables and the expansion window.
// Assumes page_hit is already address-only and PER_COUNT <= NIB_W.
module io_dec #(
    parameter int NIB_W     = bus_dec_pkg::NIB_W,
    parameter int PER_COUNT = bus_dec_pkg::PER_COUNT,
    parameter logic [NIB_W-1:0] LAT0_NIB = bus_dec_pkg::LAT0_NIB,
    parameter logic [NIB_W-1:0] LAT1_NIB = bus_dec_pkg::LAT1_NIB
) (
    input  logic             page_hit,
    input  logic [NIB_W-1:0] nib,
    input  logic             phi2,
    output logic             per65_hit,
    output logic             lat0_en,
    output logic             lat1_en,
    output logic             xio_hit
);
    logic [PER_COUNT-1:0] win_hit;

    // One window per peripheral: exactly its own nibble bit set.
    for (genvar i = 0; i < PER_COUNT; i++) begin : g_win
        localparam logic [NIB_W-1:0] WIN_NIB = NIB_W'(1) << i;
        always_comb win_hit[i] = (nib == WIN_NIB);
    end

    // Combine windows and decode the remaining page slots.
    always_comb begin
        per65_hit = page_hit & (|win_hit);
        lat0_en   = page_hit & (nib == LAT0_NIB) & phi2;
        lat1_en   = page_hit & (nib == LAT1_NIB) & phi2;
        xio_hit   = page_hit & nib[NIB_W-1] & nib[NIB_W-2];
    end
endmodule

// File: rtl/bus_decoder_65.sv
// Module: bus_decoder_65
// Top of the 65xx bus decoder. Chip selects are address-only, while strobes
// and latch enables are qualified by phi2. All outputs are active low.
// Assumes a purely combinational use; no reset is needed.
module bus_decoder_65 (
    input  logic [11:0] addr_hi,
    input  logic        rw,
    input  logic        phi2,
    output logic        rd_n,
    output logic        wr_n,
    output logic        per65_cs_n,
    output logic        latch0_en_n,
    output logic        latch1_en_n,
    output logic        xio_cs_n,
    output logic        ram_cs_n,
    output logic        rom_cs_n
);
    import bus_dec_pkg::*;

    logic rd_en, wr_en;
    logic ram_hit, rom_hit, page_hit;
    logic per65_hit, lat0_en, lat1_en, xio_hit;

    strobe_gen u_strobe (
        .rw    (rw),
        .phi2  (phi2),
        .rd_en (rd_en),
        .wr_en (wr_en)
    );

    region_dec #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .IO_PAGE(IO_PAGE)) u_region (
        .addr_hi  (addr_hi),
        .ram_hit  (ram_hit),
        .rom_hit  (rom_hit),
        .page_hit (page_hit)
    );

    io_dec #(.NIB_W(NIB_W), .PER_COUNT(PER_COUNT),
             .LAT0_NIB(LAT0_NIB), .LAT1_NIB(LAT1_NIB)) u_io (
        .page_hit  (page_hit),
        .nib       (addr_hi[NIB_W-1:0]),
        .phi2      (phi2),
        .per65_hit (per65_hit),
        .lat0_en   (lat0_en),
        .lat1_en   (lat1_en),
        .xio_hit   (xio_hit)
    );

    // Drive the active-low output pins.
    always_comb begin
        rd_n        = ~rd_en;
        wr_n        = ~wr_en;
        per65_cs_n  = ~per65_hit;
        latch0_en_n = ~lat0_en;
        latch1_en_n = ~lat1_en;
        xio_cs_n    = ~xio_hit;
        ram_cs_n    = ~ram_hit;
        rom_cs_n    = ~rom_hit;
    end

    // Guard the exclusivity and phase rules across the three submodules.
    always_comb begin
        // R9
        strobe_excl_chk: assert (rd_n | wr_n);
        // R9
        phase_low_idle_chk: assert (phi2 | (rd_n & wr_n & latch0_en_n & latch1_en_n));
        // R8
        sel_excl_chk: assert ($countones({~ram_cs_n, ~rom_cs_n, ~per65_cs_n,
                                          ~xio_cs_n, ~latch0_en_n, ~latch1_en_n}) <= 1);
        // R7
        ram_top_gap_chk: assert ((addr_hi != 12'h800) |
                                 (per65_cs_n & xio_cs_n & latch0_en_n & latch1_en_n
                                  & ram_cs_n & rom_cs_n));
    end
endmodule

// File: tb/bus_decoder_65_tb.sv
module bus_decoder_65_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 60000;
    localparam int RAND_VECS  = 3000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr_hi = '0;
    logic        rw = 1'b1;
    logic        phi2 = 1'b0;
    logic rd_n, wr_n, per65_cs_n, latch0_en_n, latch1_en_n, xio_cs_n, ram_cs_n, rom_cs_n;

    int vecs  = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_decoder_65 u_dut (
        .addr_hi(addr_hi), .rw(rw), .phi2(phi2),
        .rd_n(rd_n), .wr_n(wr_n), .per65_cs_n(per65_cs_n),
        .latch0_en_n(latch0_en_n), .latch1_en_n(latch1_en_n),
        .xio_cs_n(xio_cs_n), .ram_cs_n(ram_cs_n), .rom_cs_n(rom_cs_n)
    );

    // Reference values as active-high truth, from byte-address ranges.
    function automatic logic [7:0] expect_hi(input logic [11:0] a, input logic r, input logic p);
        int full = int'(a) * 16;
        int nb   = int'(a[3:0]);
        logic ram, rom, per, l0, l1, xio, rd, wr;
        ram = (full < 32'h8000);
        rom = (full >= 32'hC000);
        per = ((full / 256) == 32'h80) && (nb == 1 || nb == 2 || nb == 4 || nb == 8);
        l0  = (full >= 32'h8050) && (full <= 32'h805F) && p;
        l1  = (full >= 32'h8060) && (full <= 32'h806F) && p;
        xio = (full >= 32'h80C0) && (full <= 32'h80FF);
        rd  = r && p;
        wr  = !r && p;
        return {rd, wr, per, l0, l1, xio, ram, rom};
    endfunction

    task automatic chk(input string req, input string name, input logic act, input logic exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s addr=%03h rw=%0b phi2=%0b actual=%0b expected=%0b",
                     req, name, addr_hi, rw, phi2, act, exp);
        end
    endtask

    task automatic apply(input logic [11:0] a, input logic r, input logic p);
        logic [7:0] e;
        logic [7:0] got;
        @(posedge clk);
        addr_hi = a; rw = r; phi2 = p;
        @(negedge clk);
        e   = ~expect_hi(a, r, p);
        got = {rd_n, wr_n, per65_cs_n, latch0_en_n, latch1_en_n, xio_cs_n, ram_cs_n, rom_cs_n};
        chk("R1", "rd_n",        got[7], e[7]);
        chk("R2", "wr_n",        got[6], e[6]);
        chk("R3", "per65_cs_n",  got[5], e[5]);
        chk("R4", "latch0_en_n", got[4], e[4]);
        chk("R4", "latch1_en_n", got[3], e[3]);
        chk("R5", "xio_cs_n",    got[2], e[2]);
        chk("R6", "ram_cs_n",    got[1], e[1]);
        chk("R6", "rom_cs_n",    got[0], e[0]);
        // R8: at most one select or latch enable low
        chk("R8", "sel_count_le1", ($countones(~got[5:0]) <= 1), 1'b1);
        // R9: strobes never low together, idle while phi2 low
        chk("R9", "strobe_excl", (got[7] | got[6]), 1'b1);
        if (!p) chk("R9", "idle_low_phase", &{got[7], got[6], got[4], got[3]}, 1'b1);
        // R7: probe just above RAM touches nothing
        if (a == 12'h800) chk("R7", "top_gap_quiet", &got[5:0], 1'b1);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all-reqs actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20150408));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Reset state: idle bus, low phase, address zero (R9, R6)
        apply(12'h000, 1'b1, 1'b0);
        // Directed corners: R7 top-of-RAM probe, R4 latch slots, R3/R5 edges
        apply(12'h800, 1'b0, 1'b1);
        apply(12'h800, 1'b1, 1'b1);
        apply(12'h805, 1'b0, 1'b1);
        apply(12'h806, 1'b1, 1'b1);
        apply(12'h805, 1'b0, 1'b0);
        apply(12'h808, 1'b1, 1'b0);
        apply(12'h803, 1'b1, 1'b1);
        apply(12'h80C, 1'b0, 1'b1);
        apply(12'h80F, 1'b1, 1'b0);
        apply(12'h7FF, 1'b0, 1'b1);
        apply(12'hBFF, 1'b1, 1'b1);
        apply(12'hC00, 1'b1, 1'b1);
        // Exhaustive sweep over every address group and rw/phi2 combination
        for (int a = 0; a < 4096; a++)
            for (int c = 0; c < 4; c++)
                apply(12'(a), c[0], c[1]);
        // Seeded random mix, biased toward the I/O page
        for (int k = 0; k < RAND_VECS; k++) begin
            logic [11:0] ra = 12'($urandom);
            if ($urandom % 2 == 0) ra[11:4] = 8'h80;
            apply(ra, 1'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule